// File: doc/BRIEF.md
# DisplayPort Link Training Controller

This block trains a DisplayPort main link of up to four lanes. Software or a sequencer pulses `start`. The block then goes through a fixed series of sink register accesses, which it issues on an abstract register-transfer port. A separate transfer engine carries out each request and answers with a done pulse, an error flag and up to six read bytes.

The block first reads the sink's capability bytes and rejects unsupported rates or a zero lane count. It wakes the sink to power state D0 when the sink revision allows this. It then programs the link rate and lane count. Next comes clock recovery on training pattern 1, followed by channel equalization on training pattern 2. In each loop iteration the block applies a single drive setting to all active lanes, waits a fixed interval, reads six status bytes and folds the sink's adjustment requests into a new common setting.

The outputs are the pattern select, the per-lane drive bytes for the PHY, the negotiated rate and lane count, and a pass or fail result. The result is held until the next start. Wait intervals are counted in clock cycles derived from the `TICKS_PER_US` parameter.

Top module: `dp_link_trainer`

## Requirements
- R1: On start the block reads 3 bytes at sink address 0x00000: byte 0 is the revision, byte 1 the rate code and byte 2 the lane count (its low five bits). Only rate codes 0x06 and 0x0A are accepted, and a lane count of zero is refused. A refused capability ends training as a fail with no further transfer, and `linkRate`/`laneCount` show the stored values.
- R2: If the revision is 0x11 or higher, the block reads 1 byte at 0x00600. It writes that byte back with bits [1:0] set to 01 and the other bits kept, then waits 1000*TICKS_PER_US cycles. With a lower revision, address 0x00600 is never accessed.
- R3: The rate and lane count are written as 2 bytes at 0x00100: the rate in byte 0 and the lane count in byte 1.
- R4: Clock recovery sets `patternSel` to 1 (pattern select 0 = off, 1 = pattern 1, 2 = pattern 2). It writes 1 byte of value 1 at 0x00102, with the drive setting cleared to zero.
- R5: Each clock recovery iteration writes the drive byte to 0x00103, repeated once per active lane, with a length of min(lane count, 4). The block then waits at least 1000*TICKS_PER_US cycles before it reads 6 status bytes at 0x00202.
- R6: The status nibble of lane n sits in status byte n>>1, in bits [7:4] when n is odd and bits [3:0] when n is even. Clock recovery passes when bit 0 of the nibble is set for every active lane; inactive lanes are ignored.
- R7: The adjustment nibble of lane n sits in status byte 4+(n>>1) at the same nibble position: bits [1:0] hold the voltage level and bits [3:2] the pre-emphasis level. The new drive byte is built from the maximum voltage and the maximum pre-emphasis across the active lanes. The voltage goes in bits [1:0], bit 2 is set when the voltage is 3, the pre-emphasis goes in bits [4:3], and bit 5 is set when the pre-emphasis is 3.
- R8: A failed clock recovery status read while the applied drive byte already has bit 2 set ends training as a fail.
- R9: A failed clock recovery iteration whose applied voltage equals the previous iteration's voltage increments a repeat count, and a changed voltage clears that count. Training fails on the iteration where the count would reach 5.
- R10: When clock recovery passes, `patternSel` becomes 2 and 1 byte of value 2 is written at 0x00102. Equalization keeps the drive setting that clock recovery ended with and issues no lane write. Each equalization iteration waits 400*TICKS_PER_US cycles, and no more than 1000*TICKS_PER_US, before the status read.
- R11: Equalization passes when bit 0 of status byte 2 is set and bits [2:0] of every active lane's nibble are all set. Otherwise the drive is adjusted as in R7. After the fifth failed status read, training fails.
- R12: A transfer answered with the error flag ends training at once as a fail, and no further transfer is requested.
- R13: After reset, `busy`, `finished`, `pass`, `patternSel`, `laneDrive` and `xferReq` are 0. `busy` is high while training runs. `finished` and `pass` hold the result until the next start. Lanes at or above the lane count drive 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse to begin training |
| busy | output | 1 | Training in progress |
| finished | output | 1 | Training ended; result valid |
| pass | output | 1 | Training succeeded |
| patternSel | output | 2 | Training pattern select for the PHY |
| laneDrive | output | 32 | Drive byte per lane, lane n at bits [8n+7:8n] |
| linkRate | output | 8 | Rate code read from the sink |
| laneCount | output | 5 | Lane count read from the sink |
| xferReq | output | 1 | Transfer request, held until done |
| xferWrite | output | 1 | 1 = write, 0 = read |
| xferAddr | output | 20 | Sink register address |
| xferLen | output | 3 | Byte count |
| xferWrData | output | 32 | Write bytes, byte k at bits [8k+7:8k] |
| xferDone | input | 1 | Transfer complete pulse |
| xferErr | input | 1 | Transfer failed, valid with done |
| xferRdData | input | 48 | Read bytes, byte k at bits [8k+7:8k], valid with done |

## Verification
The bench models the sink and scripts its status answers per read. This lets it target the two early exits from clock recovery. A design that tested the max-swing flag on the new setting instead of the applied one would quit one read early. A repeat counter that does not clear on a voltage change would give up after six reads instead of seven. The bench also feeds adjustment requests on inactive lanes, which must not raise the drive. It feeds a capability lane byte with high bits set, which must mask to the right count. It checks the spacing between requests against the wait intervals, and it injects a transfer error part-way through a run, after which no further request may follow.

// File: rtl/dplt_pkg.sv
package dplt_pkg;
  localparam int LANES      = 4;
  localparam int STAT_BYTES = 6;
  localparam int ALIGN_BYTE = 2;
  localparam int ADJ_BYTE   = 4;
  localparam int SWING_MAX_BIT = 2;

  localparam logic [19:0] ADDR_CAP      = 20'h00000;
  localparam logic [19:0] ADDR_BW       = 20'h00100;
  localparam logic [19:0] ADDR_PATTERN  = 20'h00102;
  localparam logic [19:0] ADDR_LANE_SET = 20'h00103;
  localparam logic [19:0] ADDR_STATUS   = 20'h00202;
  localparam logic [19:0] ADDR_POWER    = 20'h00600;

  localparam logic [7:0] RATE_LOW  = 8'h06;
  localparam logic [7:0] RATE_HIGH = 8'h0A;
  localparam logic [7:0] REV_POWER = 8'h11;
  localparam logic [7:0] PWR_MASK  = 8'h03;
  localparam logic [7:0] PWR_D0    = 8'h01;

  typedef enum logic [4:0] {
    S_IDLE, S_CAP_RD, S_CAP_CHK, S_PWR_RD, S_PWR_WR, S_PWR_WAIT, S_CFG_WR,
    S_TP1_WR, S_CR_APPLY, S_CR_WAIT, S_CR_RD, S_CR_EVAL, S_TP2_WR,
    S_EQ_WAIT, S_EQ_RD, S_EQ_EVAL
  } trainState_t;

  typedef struct packed {
    logic ldCap;
    logic ldPower;
    logic ldStatus;
    logic clrTrain;
    logic adjTrain;
    logic crStep;
    logic clrEq;
    logic eqStep;
  } dpCtl_t;
endpackage

// File: rtl/dplt_datapath.sv
module dplt_datapath
  import dplt_pkg::*;
#(
  parameter int CR_LIMIT = 5,
  parameter int EQ_LIMIT = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtl_t                  ctl,
  input  logic [STAT_BYTES*8-1:0] rdData,
  output logic [7:0]              linkRate,
  output logic [4:0]              laneCount,
  output logic [2:0]              laneUse,
  output logic [7:0]              powerByte,
  output logic [7:0]              trainSet,
  output logic                    capOk,
  output logic                    revPower,
  output logic                    crOk,
  output logic                    eqOk,
  output logic                    maxSwing,
  output logic                    crGiveUp,
  output logic                    eqGiveUp,
  output logic [LANES*8-1:0]      laneDrive
);
  localparam int TW = $clog2(CR_LIMIT + 1);
  localparam int EW = $clog2(EQ_LIMIT + 1);

  logic [7:0] capRev;
  logic [STAT_BYTES-1:0][7:0] statReg;
  logic [1:0] prevVolt;
  logic prevValid;
  logic [TW-1:0] tries;
  logic [EW-1:0] eqCnt;
  logic [1:0] vMax, pMax;
  logic [3:0] nib, adj;
  logic [7:0] newSet;
  logic sameVolt;

  assign laneUse  = (laneCount >= 5'(LANES)) ? 3'(LANES) : laneCount[2:0];
  assign capOk    = ((linkRate == RATE_LOW) || (linkRate == RATE_HIGH)) && (laneCount != 5'd0);
  assign revPower = (capRev >= REV_POWER);
  assign maxSwing = trainSet[SWING_MAX_BIT];
  assign sameVolt = prevValid && (trainSet[1:0] == prevVolt);
  assign crGiveUp = sameVolt && (tries == TW'(CR_LIMIT - 1));
  assign eqGiveUp = (eqCnt == EW'(EQ_LIMIT - 1));

  // status evaluation and merge of adjustment requests over active lanes
  always_comb begin
    crOk = 1'b1;
    eqOk = statReg[ALIGN_BYTE][0];
    vMax = 2'd0;
    pMax = 2'd0;
    nib  = 4'd0;
    adj  = 4'd0;
    for (int i = 0; i < LANES; i++) begin
      if (3'(i) < laneUse) begin
        nib  = statReg[i/2][4*(i%2) +: 4];
        adj  = statReg[ADJ_BYTE + i/2][4*(i%2) +: 4];
        crOk = crOk & nib[0];
        eqOk = eqOk & (&nib[2:0]);
        if (adj[1:0] > vMax) vMax = adj[1:0];
        if (adj[3:2] > pMax) pMax = adj[3:2];
      end
    end
    newSet = {2'b00, pMax == 2'd3, pMax, vMax == 2'd3, vMax};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capRev    <= '0;
      linkRate  <= '0;
      laneCount <= '0;
      powerByte <= '0;
      statReg   <= '0;
      trainSet  <= '0;
      prevVolt  <= '0;
      prevValid <= 1'b0;
      tries     <= '0;
      eqCnt     <= '0;
    end else begin
      if (ctl.ldCap) begin
        capRev    <= rdData[7:0];
        linkRate  <= rdData[15:8];
        laneCount <= rdData[20:16];
      end
      if (ctl.ldPower)  powerByte <= rdData[7:0];
      if (ctl.ldStatus) statReg   <= rdData;
      if (ctl.clrTrain) begin
        trainSet  <= '0;
        prevVolt  <= '0;
        prevValid <= 1'b0;
        tries     <= '0;
      end else begin
        if (ctl.crStep) begin
          tries     <= sameVolt ? tries + 1'b1 : '0;
          prevVolt  <= trainSet[1:0];
          prevValid <= 1'b1;
        end
        if (ctl.adjTrain) trainSet <= newSet;
      end
      if (ctl.clrEq)       eqCnt <= '0;
      else if (ctl.eqStep) eqCnt <= eqCnt + 1'b1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneDrive[8*g +: 8] = (3'(g) < laneUse) ? trainSet : 8'h00;
  end

  p_tries_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    tries < TW'(CR_LIMIT));
  p_eq_bound_r11: assert property (@(posedge clk) disable iff (!rstN)
    eqCnt < EW'(EQ_LIMIT));
endmodule

// File: rtl/dplt_control.sv
module dplt_control
  import dplt_pkg::*;
#(
  parameter int TICKS_PER_US = 100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [7:0]         linkRate,
  input  logic [4:0]         laneCount,
  input  logic [2:0]         laneUse,
  input  logic [7:0]         powerByte,
  input  logic [7:0]         trainSet,
  input  logic               capOk,
  input  logic               revPower,
  input  logic               crOk,
  input  logic               eqOk,
  input  logic               maxSwing,
  input  logic               crGiveUp,
  input  logic               eqGiveUp,
  input  logic               xferDone,
  input  logic               xferErr,
  output dpCtl_t             ctl,
  output logic               busy,
  output logic               finished,
  output logic               pass,
  output logic [1:0]         patternSel,
  output logic               xferReq,
  output logic               xferWrite,
  output logic [19:0]        xferAddr,
  output logic [2:0]         xferLen,
  output logic [LANES*8-1:0] xferWrData
);
  localparam int MS_TICKS = 1000 * TICKS_PER_US;
  localparam int EQ_TICKS = 400 * TICKS_PER_US;
  localparam int WW = $clog2(MS_TICKS + 1);

  trainState_t state;
  logic [WW-1:0] waitCnt;

  assign busy = (state != S_IDLE);

  always_comb begin
    xferReq = 1'b0; xferWrite = 1'b0; xferAddr = '0; xferLen = '0; xferWrData = '0;
    case (state)
      S_CAP_RD:  begin xferReq = 1'b1; xferAddr = ADDR_CAP; xferLen = 3'd3; end
      S_PWR_RD:  begin xferReq = 1'b1; xferAddr = ADDR_POWER; xferLen = 3'd1; end
      S_PWR_WR:  begin
        xferReq = 1'b1; xferWrite = 1'b1; xferAddr = ADDR_POWER; xferLen = 3'd1;
        xferWrData[7:0] = (powerByte & ~PWR_MASK) | PWR_D0;
      end
      S_CFG_WR:  begin
        xferReq = 1'b1; xferWrite = 1'b1; xferAddr = ADDR_BW; xferLen = 3'd2;
        xferWrData[15:0] = {3'b000, laneCount, linkRate};
      end
      S_TP1_WR:  begin
        xferReq = 1'b1; xferWrite = 1'b1; xferAddr = ADDR_PATTERN; xferLen = 3'd1;
        xferWrData[7:0] = 8'd1;
      end
      S_CR_APPLY: begin
        xferReq = 1'b1; xferWrite = 1'b1; xferAddr = ADDR_LANE_SET; xferLen = laneUse;
        xferWrData = {LANES{trainSet}};
      end
      S_CR_RD, S_EQ_RD: begin xferReq = 1'b1; xferAddr = ADDR_STATUS; xferLen = 3'd6; end
      S_TP2_WR:  begin
        xferReq = 1'b1; xferWrite = 1'b1; xferAddr = ADDR_PATTERN; xferLen = 3'd1;
        xferWrData[7:0] = 8'd2;
      end
      default: ;
    endcase
  end

  always_comb begin
    ctl = '0;
    ctl.clrTrain = (state == S_IDLE) && start;
    ctl.ldCap    = (state == S_CAP_RD) && xferDone && !xferErr;
    ctl.ldPower  = (state == S_PWR_RD) && xferDone && !xferErr;
    ctl.ldStatus = ((state == S_CR_RD) || (state == S_EQ_RD)) && xferDone && !xferErr;
    ctl.crStep   = (state == S_CR_EVAL) && !crOk && !maxSwing && !crGiveUp;
    ctl.clrEq    = (state == S_CR_EVAL) && crOk;
    ctl.eqStep   = (state == S_EQ_EVAL) && !eqOk && !eqGiveUp;
    ctl.adjTrain = ctl.crStep || ctl.eqStep;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; waitCnt <= '0; finished <= 1'b0; pass <= 1'b0; patternSel <= 2'd0;
    end else if (xferReq && xferDone && xferErr) begin
      state <= S_IDLE; finished <= 1'b1; pass <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_CAP_RD; finished <= 1'b0; pass <= 1'b0; patternSel <= 2'd0;
        end
        S_CAP_RD: if (xferDone) state <= S_CAP_CHK;
        S_CAP_CHK:
          if (!capOk) begin state <= S_IDLE; finished <= 1'b1; end
          else state <= revPower ? S_PWR_RD : S_CFG_WR;
        S_PWR_RD: if (xferDone) state <= S_PWR_WR;
        S_PWR_WR: if (xferDone) begin state <= S_PWR_WAIT; waitCnt <= WW'(MS_TICKS - 1); end
        S_PWR_WAIT: if (waitCnt == '0) state <= S_CFG_WR; else waitCnt <= waitCnt - 1'b1;
        S_CFG_WR: if (xferDone) begin state <= S_TP1_WR; patternSel <= 2'd1; end
        S_TP1_WR: if (xferDone) state <= S_CR_APPLY;
        S_CR_APPLY: if (xferDone) begin state <= S_CR_WAIT; waitCnt <= WW'(MS_TICKS - 1); end
        S_CR_WAIT: if (waitCnt == '0) state <= S_CR_RD; else waitCnt <= waitCnt - 1'b1;
        S_CR_RD: if (xferDone) state <= S_CR_EVAL;
        S_CR_EVAL:
          if (crOk) begin state <= S_TP2_WR; patternSel <= 2'd2; end
          else if (maxSwing || crGiveUp) begin state <= S_IDLE; finished <= 1'b1; end
          else state <= S_CR_APPLY;
        S_TP2_WR: if (xferDone) begin state <= S_EQ_WAIT; waitCnt <= WW'(EQ_TICKS - 1); end
        S_EQ_WAIT: if (waitCnt == '0) state <= S_EQ_RD; else waitCnt <= waitCnt - 1'b1;
        S_EQ_RD: if (xferDone) state <= S_EQ_EVAL;
        S_EQ_EVAL:
          if (eqOk) begin state <= S_IDLE; finished <= 1'b1; pass <= 1'b1; end
          else if (eqGiveUp) begin state <= S_IDLE; finished <= 1'b1; end
          else begin state <= S_EQ_WAIT; waitCnt <= WW'(EQ_TICKS - 1); end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    xferReq && !xferDone |=> xferReq && $stable(xferAddr));
  p_err_stop_r12: assert property (@(posedge clk) disable iff (!rstN)
    xferReq && xferDone && xferErr |=> !xferReq && finished && !pass);
  p_power_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    xferReq && (xferAddr == ADDR_POWER) |-> revPower);
  p_rate_gate_r1: assert property (@(posedge clk) disable iff (!rstN)
    (patternSel != 2'd0) |-> capOk);
  p_lane_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    xferReq && (xferAddr == ADDR_LANE_SET) |-> (patternSel == 2'd1));
  p_pass_eq_r11: assert property (@(posedge clk) disable iff (!rstN)
    finished && pass |-> (patternSel == 2'd2));
endmodule

// File: rtl/dp_link_trainer.sv
module dp_link_trainer
  import dplt_pkg::*;
#(
  parameter int TICKS_PER_US = 100,
  parameter int CR_LIMIT     = 5,
  parameter int EQ_LIMIT     = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output logic        busy,
  output logic        finished,
  output logic        pass,
  output logic [1:0]  patternSel,
  output logic [31:0] laneDrive,
  output logic [7:0]  linkRate,
  output logic [4:0]  laneCount,
  output logic        xferReq,
  output logic        xferWrite,
  output logic [19:0] xferAddr,
  output logic [2:0]  xferLen,
  output logic [31:0] xferWrData,
  input  logic        xferDone,
  input  logic        xferErr,
  input  logic [47:0] xferRdData
);
  dpCtl_t ctl;
  logic [2:0] laneUse;
  logic [7:0] powerByte, trainSet;
  logic capOk, revPower, crOk, eqOk, maxSwing, crGiveUp, eqGiveUp;

  dplt_datapath #(.CR_LIMIT(CR_LIMIT), .EQ_LIMIT(EQ_LIMIT)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdData(xferRdData),
    .linkRate(linkRate), .laneCount(laneCount), .laneUse(laneUse),
    .powerByte(powerByte), .trainSet(trainSet), .capOk(capOk),
    .revPower(revPower), .crOk(crOk), .eqOk(eqOk), .maxSwing(maxSwing),
    .crGiveUp(crGiveUp), .eqGiveUp(eqGiveUp), .laneDrive(laneDrive)
  );

  dplt_control #(.TICKS_PER_US(TICKS_PER_US)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .linkRate(linkRate),
    .laneCount(laneCount), .laneUse(laneUse), .powerByte(powerByte),
    .trainSet(trainSet), .capOk(capOk), .revPower(revPower), .crOk(crOk),
    .eqOk(eqOk), .maxSwing(maxSwing), .crGiveUp(crGiveUp), .eqGiveUp(eqGiveUp),
    .xferDone(xferDone), .xferErr(xferErr), .ctl(ctl), .busy(busy),
    .finished(finished), .pass(pass), .patternSel(patternSel),
    .xferReq(xferReq), .xferWrite(xferWrite), .xferAddr(xferAddr),
    .xferLen(xferLen), .xferWrData(xferWrData)
  );
endmodule

// File: tb/dp_link_trainer_test.sv
`timescale 1ns/1ps
module dp_link_trainer_test;
  localparam int T  = 2;
  localparam int MS = 1000 * T;
  localparam int EQ = 400 * T;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic busy, finished, pass, xferReq, xferWrite;
  logic [1:0] patternSel;
  logic [31:0] laneDrive, xferWrData;
  logic [7:0] linkRate;
  logic [4:0] laneCount;
  logic [19:0] xferAddr;
  logic [2:0] xferLen;
  logic xferDone, xferErr;
  logic [47:0] xferRdData;

  always #10 clk = ~clk;

  dp_link_trainer #(.TICKS_PER_US(T)) uut (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .finished(finished),
    .pass(pass), .patternSel(patternSel), .laneDrive(laneDrive),
    .linkRate(linkRate), .laneCount(laneCount), .xferReq(xferReq),
    .xferWrite(xferWrite), .xferAddr(xferAddr), .xferLen(xferLen),
    .xferWrData(xferWrData), .xferDone(xferDone), .xferErr(xferErr),
    .xferRdData(xferRdData)
  );

  int checks = 0, errors = 0, cyc = 0;
  int nLog = 0, nStat = 0, errIdx = -1;
  logic [19:0] logAddr [64];
  logic        logWr   [64];
  logic [2:0]  logLen  [64];
  logic [31:0] logData [64];
  logic [31:0] logDrive[64];
  logic [1:0]  logPat  [64];
  int          logTime [64];
  logic [47:0] statTab [16];
  logic [47:0] capBytes;
  logic [7:0]  pwrByte;

  always @(posedge clk) cyc <= cyc + 1;

  // sink and transfer engine model
  initial begin
    xferDone = 1'b0; xferErr = 1'b0; xferRdData = '0;
    forever begin
      @(negedge clk);
      if (xferReq) begin
        automatic int idx = nLog;
        automatic logic [47:0] rd = '0;
        if (idx < 64) begin
          logAddr[idx] = xferAddr; logWr[idx] = xferWrite; logLen[idx] = xferLen;
          logData[idx] = xferWrData; logDrive[idx] = laneDrive;
          logPat[idx] = patternSel; logTime[idx] = cyc;
        end
        nLog++;
        if (xferAddr == 20'h00000) rd = capBytes;
        else if (xferAddr == 20'h00600) rd = {40'h0, pwrByte};
        else if (xferAddr == 20'h00202) begin
          if (nStat < 16) rd = statTab[nStat];
          nStat++;
        end
        repeat (2) @(negedge clk);
        xferRdData = rd; xferErr = (idx == errIdx); xferDone = 1'b1;
        @(negedge clk);
        xferDone = 1'b0; xferErr = 1'b0;
      end
    end
  end

  function automatic logic [47:0] mkStat(input logic [7:0] b0, b1, b2, b4, b5);
    return {b5, b4, 8'h00, b2, b1, b0};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chkRange(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic setup(input logic [7:0] rev, rate, lanes);
    capBytes = {24'h0, lanes, rate, rev};
    nLog = 0; nStat = 0; errIdx = -1; pwrByte = 8'h00;
    for (int i = 0; i < 16; i++) statTab[i] = '0;
  endtask

  task automatic runTrain();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R13 busy during run", busy, 1);
    while (!finished) @(negedge clk);
    @(negedge clk);
    chk("R13 busy low at end", busy, 0);
  endtask

  task automatic testReset();
    chk("R13 reset busy", busy, 0);
    chk("R13 reset finished", finished, 0);
    chk("R13 reset pass", pass, 0);
    chk("R13 reset pattern", patternSel, 0);
    chk("R13 reset drive", laneDrive, 0);
    chk("R13 reset req", xferReq, 0);
  endtask

  task automatic testBadCaps();
    setup(8'h12, 8'h14, 8'h04);
    runTrain();
    chk("R1 bad rate fails", pass, 0);
    chk("R1 bad rate single transfer", nLog, 1);
    chk("R1 cap read len", logLen[0], 3);
    chk("R1 rate output", linkRate, 8'h14);
    setup(8'h12, 8'h0A, 8'h80);
    runTrain();
    chk("R1 zero lanes fails", pass, 0);
    chk("R1 zero lanes single transfer", nLog, 1);
    chk("R1 zero lanes count", laneCount, 0);
  endtask

  task automatic testFullFourLane();
    setup(8'h12, 8'h0A, 8'h84);
    pwrByte = 8'hF2;
    statTab[0] = mkStat(8'h00, 8'h00, 8'h00, 8'h09, 8'h06);
    statTab[1] = mkStat(8'h11, 8'h11, 8'h00, 8'h00, 8'h00);
    statTab[2] = mkStat(8'h11, 8'h11, 8'h00, 8'h30, 8'h00);
    statTab[3] = mkStat(8'h77, 8'h77, 8'h01, 8'h00, 8'h00);
    runTrain();
    chk("R11 four lane pass", pass, 1);
    chk("R13 finished held", finished, 1);
    chk("R1 lane count masked", laneCount, 4);
    chk("R1 rate kept", linkRate, 8'h0A);
    chk("R11 transfer count", nLog, 12);
    chk("R2 power read addr", logAddr[1], 20'h00600);
    chk("R2 power read is read", logWr[1], 0);
    chk("R2 power write data", {logWr[2], logAddr[2], logData[2][7:0]}, {1'b1, 20'h00600, 8'hF1});
    chkRange("R2 power wait", logTime[3] - logTime[2], MS, MS + 10);
    chk("R3 config write", {logWr[3], logAddr[3], logLen[3], logData[3][15:0]},
        {1'b1, 20'h00100, 3'd2, 16'h040A});
    chk("R4 pattern1 write", {logAddr[4], logData[4][7:0], logPat[4]}, {20'h00102, 8'h01, 2'd1});
    chk("R4 zero drive first apply", {logAddr[5], logLen[5], logData[5]}, {20'h00103, 3'd4, 32'h0});
    chkRange("R5 cr wait", logTime[6] - logTime[5], MS, MS + 10);
    chk("R5 status read", {logAddr[6], logLen[6]}, {20'h00202, 3'd6});
    chk("R7 merged drive", {logAddr[7], logData[7]}, {20'h00103, 32'h12121212});
    chk("R6 cr passes on nibble bit0", {logAddr[9], logData[9][7:0], logPat[9]},
        {20'h00102, 8'h02, 2'd2});
    chk("R10 eq keeps cr drive", logDrive[9], 32'h12121212);
    chkRange("R10 eq wait", logTime[10] - logTime[9], EQ, MS - 1);
    chk("R10 no lane write in eq", logAddr[11], 20'h00202);
    chk("R7 swing flag drive", laneDrive, 32'h07070707);
    chk("R11 pattern held", patternSel, 2);
  endtask

  task automatic testTwoLaneOldRev();
    setup(8'h10, 8'h06, 8'h02);
    statTab[0] = mkStat(8'h00, 8'h00, 8'h00, 8'h01, 8'h03);
    statTab[1] = mkStat(8'h11, 8'h00, 8'h00, 8'h00, 8'h00);
    statTab[2] = mkStat(8'h77, 8'h00, 8'h01, 8'h00, 8'h00);
    runTrain();
    chk("R11 two lane pass", pass, 1);
    chk("R2 no power access", nLog, 9);
    chk("R3 config after cap", {logAddr[1], logData[1][15:0]}, {20'h00100, 16'h0206});
    chk("R5 lane write length", logLen[3], 2);
    chk("R7 inactive lane request ignored", logData[5][15:0], 16'h0101);
    chk("R13 inactive lanes drive zero", laneDrive, 32'h00000101);
  endtask

  task automatic testMaxSwing();
    setup(8'h10, 8'h06, 8'h01);
    statTab[0] = mkStat(8'h00, 8'h00, 8'h00, 8'h0F, 8'h00);
    statTab[1] = mkStat(8'h00, 8'h00, 8'h00, 8'h0F, 8'h00);
    runTrain();
    chk("R8 max swing fails", pass, 0);
    chk("R8 max swing status reads", nStat, 2);
    chk("R7 both max flags", laneDrive, 32'h0000003F);
  endtask

  task automatic testRepeat();
    setup(8'h10, 8'h06, 8'h01);
    for (int i = 0; i < 16; i++) statTab[i] = mkStat(8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    runTrain();
    chk("R9 same voltage fails", pass, 0);
    chk("R9 same voltage reads", nStat, 6);
    setup(8'h10, 8'h06, 8'h01);
    for (int i = 0; i < 16; i++) statTab[i] = mkStat(8'h00, 8'h00, 8'h00, 8'h01, 8'h00);
    runTrain();
    chk("R9 count cleared on change", nStat, 7);
    chk("R9 pattern stays 1", patternSel, 1);
  endtask

  task automatic testEqExhaust();
    setup(8'h10, 8'h06, 8'h01);
    statTab[0] = mkStat(8'h01, 8'h00, 8'h00, 8'h00, 8'h00);
    for (int i = 1; i < 5; i++) statTab[i] = mkStat(8'h07, 8'h00, 8'h00, 8'h00, 8'h00);
    statTab[5] = mkStat(8'h03, 8'h00, 8'h01, 8'h00, 8'h00);
    runTrain();
    chk("R11 eq exhaust fails", pass, 0);
    chk("R11 eq read count", nStat, 6);
    chk("R10 pattern 2 at eq end", patternSel, 2);
  endtask

  task automatic testXferError();
    setup(8'h10, 8'h06, 8'h01);
    errIdx = 1;
    runTrain();
    chk("R12 error fails", pass, 0);
    repeat (50) @(negedge clk);
    chk("R12 no transfer after error", nLog, 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testBadCaps();
    testFullFourLane();
    testTwoLaneOldRev();
    testMaxSwing();
    testRepeat();
    testEqExhaust();
    testXferError();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule